// File: doc/BRIEF.md
# Programmable 16-bit Down-Counter/Timer

This block is a single 16-bit down-counter controlled through a small byte-wide register window. Software sets a 16-bit reload value (the time constant) one byte at a time, picks an output shape and the counter's sources through a mode byte, and then starts and steers the counter through a command/status byte. The counter decrements once per count tick while it is gated on. A tick is either a cycle with the clock-enable input high or a rising edge on an external count input. When the count reaches its end, the block raises an interrupt-pending flag. It then either reloads and carries on (continuous) or stops (single-cycle).

The output pin can carry a one-tick pulse at each terminal count, a one-shot window from trigger to terminal count, or a square wave that flips at each terminal count. Counting can be gated by software alone or by software and an external gate input. Starts can come from software or from a rising edge on an external trigger input, and a restart while running is honoured only when retrigger is enabled. Software reads the count byte-wise and can freeze a snapshot so that the two bytes belong to the same instant. The interrupt flags change only through an encoded 3-bit command in the command/status write.

Two state machines sit inside. The counting machine has states ST_IDLE and ST_RUN. Its start transition (ST_IDLE to ST_RUN) is taken on an accepted trigger. Its stop transition (ST_RUN to ST_IDLE) is taken at terminal count in single-cycle operation. The read-latch machine has states LAT_LIVE and LAT_FROZEN. Its freeze transition is taken on a command/status write with the snapshot bit set, and its release transition on a read of the count low byte.

Top module: `ctr16_timer`

## Requirements
- R1: Register addresses are 0 command/status, 1 mode, 2 count high byte, 3 count low byte, 4 reload high byte, 5 reload low byte. Mode and both reload bytes read back what was written, and after reset every register reads 0.
- R2: A trigger loads the reload value into the count and sets count-in-progress (status bit 0). Writing status bit 1 as 1 is a software trigger, and status bit 1 always reads 0. Status bit 2 is the gate command and reads back as written.
- R3: The count decrements by one per tick only while the gate command is 1 and, when mode bit 3 is set, the external gate input is high. Otherwise the count holds.
- R4: A tick is a cycle with cnt_en high when mode bit 5 is 0, and a rising edge of ext_cnt when mode bit 5 is 1. In the second case cnt_en is ignored, and a held-high ext_cnt counts once.
- R5: When mode bit 4 is set, a rising edge of ext_trig is a trigger. When mode bit 4 is clear, ext_trig is ignored. A trigger while count-in-progress is set reloads the count only when mode bit 2 (retrigger) is set, and is ignored otherwise.
- R6: A tick with a count of 1 is terminal count. With mode bit 7 = 1 (continuous) the count reloads and counting goes on. With mode bit 7 = 0 (single-cycle) the count becomes 0 and count-in-progress clears.
- R7: Mode bits 1:0 pick the shape: 00 pulse (high from terminal count until the next tick), 01 one-shot (high from an accepted trigger until terminal count), 10 square (flips at each terminal count, 0 after a start from idle). out_pin carries the shape only while mode bit 6 is 1, and is 0 otherwise.
- R8: Status bits 7:5 of a write are a command: 000 none, 001 clear pending (bit 5) and under-service (bit 7), 010 set under-service, 011 clear under-service, 100 set pending, 101 clear pending, 110 set enable (bit 6), 111 clear enable.
- R9: Terminal count sets pending. If pending was already set, the error flag (status bit 4) is set too. Any command that clears pending also clears the error flag. A terminal count in the same cycle as a clear command leaves pending and the error flag set.
- R10: irq is high exactly when pending and enable are set and under-service is clear.
- R11: A status write with bit 3 = 1 while the latch is live freezes a snapshot of the count. While the snapshot is frozen, status bit 3 reads 1 and the count bytes read the snapshot. Reading the low byte releases the snapshot, and later reads return the live count.
- R12: Reset clears the count, all flags, mode, reload value, out_pin and irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (releases the snapshot on a low-byte read) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| cnt_en | input | 1 | Count tick enable when the external count input is not selected |
| ext_gate | input | 1 | External gate, high allows counting when enabled |
| ext_trig | input | 1 | External trigger, rising edge |
| ext_cnt | input | 1 | External count input, rising edge |
| out_pin | output | 1 | Shaped timer output |
| irq | output | 1 | Interrupt request |

## Verification
Every register write, trigger, tick and interrupt command takes effect at the single clock edge where the strobe or input is seen, so its result shows on rdata, out_pin and irq in the cycle after that edge. rdata is combinational from registered state. The bench drives every input at a falling edge and samples 1 ns after the following falling edge, once the one rising edge has been applied. The tick task holds cnt_en for exactly N rising edges, so expected counts follow from the number of ticks. Rising-edge inputs (ext_trig, ext_cnt) are raised at a falling edge and take effect at the next rising edge. The race between a terminal count and a clear command is checked by putting both in the same cycle.

// File: rtl/ctr16_pkg.sv
package ctr16_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CSR    = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_TC_HI  = 3'd4;
    localparam logic [ADDR_W-1:0] A_TC_LO  = 3'd5;

    typedef enum logic [1:0] {
        SHP_PULSE   = 2'b00,
        SHP_ONESHOT = 2'b01,
        SHP_SQUARE  = 2'b10,
        SHP_RSVD    = 2'b11
    } shape_e;

    typedef struct packed {
        logic   cont;       // 1 continuous, 0 single-cycle
        logic   out_en;     // drive the output pin
        logic   xcnt_en;    // external count input selected
        logic   xtrig_en;   // external trigger accepted
        logic   xgate_en;   // external gate qualifies counting
        logic   retrig_en;  // restart while running
        shape_e shape;
    } mode_t;

    typedef enum logic [2:0] {
        IC_NOP     = 3'd0,
        IC_CLR_BOTH = 3'd1,
        IC_SET_IUS = 3'd2,
        IC_CLR_IUS = 3'd3,
        IC_SET_IP  = 3'd4,
        IC_CLR_IP  = 3'd5,
        IC_SET_IE  = 3'd6,
        IC_CLR_IE  = 3'd7
    } icmd_e;

    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_st_e;
    typedef enum logic {LAT_LIVE = 1'b0, LAT_FROZEN = 1'b1} lat_st_e;
endpackage

// File: rtl/ctr16_regs.sv
module ctr16_regs
    import ctr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    output mode_t             mode,
    output logic [CNT_W-1:0]  tconst,
    output logic              gate_cmd,
    output logic              sw_trig,
    output logic              icmd_vld,
    output icmd_e             icmd,
    output logic              frozen,
    output logic [CNT_W-1:0]  snap
);
    logic    wr_csr;
    logic    rd_lo;
    lat_st_e lat_q, lat_d;

    assign wr_csr   = wr_en && (addr == A_CSR);
    assign rd_lo    = rd_en && (addr == A_CNT_LO);
    assign sw_trig  = wr_csr && wdata[1];
    assign icmd_vld = wr_csr;
    assign icmd     = icmd_e'(wdata[7:5]);
    assign frozen   = (lat_q == LAT_FROZEN);

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= '0;
            tconst   <= '0;
            gate_cmd <= 1'b0;
        end else if (wr_en) begin
            unique case (addr)
                A_CSR:   gate_cmd <= wdata[2];
                A_MODE:  mode <= mode_t'(wdata);
                A_TC_HI: tconst[CNT_W-1:BYTE_W] <= wdata;
                A_TC_LO: tconst[BYTE_W-1:0] <= wdata;
                default: ;
            endcase
        end
    end

    // read latch: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= LAT_LIVE;
        else        lat_q <= lat_d;
    end

    // read latch: transitions freeze / release
    always_comb begin
        lat_d = lat_q;
        unique case (lat_q)
            LAT_LIVE:   if (wr_csr && wdata[3]) lat_d = LAT_FROZEN;
            LAT_FROZEN: if (rd_lo)              lat_d = LAT_LIVE;
        endcase
    end

    // snapshot capture on the freeze transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    snap <= '0;
        else if (lat_q == LAT_LIVE && lat_d == LAT_FROZEN) snap <= live_cnt;
    end

    // R11: a frozen snapshot stays put until the low byte is read
    assert_snap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q == LAT_FROZEN && !rd_lo) |=> (lat_q == LAT_FROZEN && $stable(snap)));
    // R11: low-byte read releases the snapshot
    assert_snap_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q == LAT_FROZEN && rd_lo) |=> (lat_q == LAT_LIVE));
endmodule

// File: rtl/ctr16_core.sv
module ctr16_core
    import ctr16_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode,
    input  logic [CNT_W-1:0] tconst,
    input  logic             gate_cmd,
    input  logic             sw_trig,
    input  logic             cnt_en,
    input  logic             ext_gate,
    input  logic             ext_trig,
    input  logic             ext_cnt,
    output logic [CNT_W-1:0] count,
    output logic             cip,
    output logic             tc_evt,
    output logic             shape_out
);
    run_st_e          st_q, st_d;
    logic             trig_q, xcnt_q;
    logic             trig_req, trig_ok, tick, gate_ok, step;
    logic [CNT_W-1:0] count_q;
    logic             shp_q;

    // input edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= 1'b0;
            xcnt_q <= 1'b0;
        end else begin
            trig_q <= ext_trig;
            xcnt_q <= ext_cnt;
        end
    end

    assign trig_req = sw_trig || (mode.xtrig_en && ext_trig && !trig_q);
    assign trig_ok  = trig_req && ((st_q == ST_IDLE) || mode.retrig_en);
    assign tick     = mode.xcnt_en ? (ext_cnt && !xcnt_q) : cnt_en;
    assign gate_ok  = gate_cmd && (!mode.xgate_en || ext_gate);
    assign step     = (st_q == ST_RUN) && gate_ok && tick && !trig_ok;
    assign tc_evt   = step && (count_q == CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions: start on accepted trigger, stop at terminal count in single-cycle
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (trig_ok)                st_d = ST_RUN;
            ST_RUN:  if (tc_evt && !mode.cont)   st_d = ST_IDLE;
        endcase
    end

    // count datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count_q <= '0;
        else if (trig_ok) count_q <= tconst;
        else if (tc_evt)  count_q <= mode.cont ? tconst : '0;
        else if (step)    count_q <= count_q - CNT_W'(1);
    end

    // output shaper
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shp_q <= 1'b0;
        end else begin
            unique case (mode.shape)
                SHP_ONESHOT: begin
                    if (trig_ok)     shp_q <= 1'b1;
                    else if (tc_evt) shp_q <= 1'b0;
                end
                SHP_SQUARE: begin
                    if (trig_ok && st_q == ST_IDLE) shp_q <= 1'b0;
                    else if (tc_evt)                shp_q <= !shp_q;
                end
                SHP_PULSE, SHP_RSVD: begin
                    if (tc_evt)             shp_q <= 1'b1;
                    else if (trig_ok || tick) shp_q <= 1'b0;
                end
            endcase
        end
    end

    assign count     = count_q;
    assign cip       = (st_q == ST_RUN);
    assign shape_out = shp_q;

    // R2: a start from idle loads the reload value and enters the run state
    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && trig_ok) |=> (st_q == ST_RUN && count_q == $past(tconst)));
    // R3: count holds while the gate is closed
    assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && !gate_ok && !trig_ok) |=> $stable(count_q));
    // R6: single-cycle terminal count stops at zero
    assert_single_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_evt && !mode.cont && !trig_ok) |=> (st_q == ST_IDLE && count_q == '0));
    // R7: one-shot output only rises from an accepted trigger
    assert_oneshot_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(shp_q) && $past(mode.shape == SHP_ONESHOT)) |-> $past(trig_ok));
endmodule

// File: rtl/ctr16_irq.sv
module ctr16_irq
    import ctr16_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tc_evt,
    input  logic  icmd_vld,
    input  icmd_e icmd,
    output logic  ip,
    output logic  ie,
    output logic  ius,
    output logic  err,
    output logic  irq
);
    logic ip_d, ie_d, ius_d, err_d;

    always_comb begin
        ip_d  = ip;
        ie_d  = ie;
        ius_d = ius;
        err_d = err;
        if (icmd_vld) begin
            unique case (icmd)
                IC_NOP:      ;
                IC_CLR_BOTH: begin ip_d = 1'b0; ius_d = 1'b0; err_d = 1'b0; end
                IC_SET_IUS:  ius_d = 1'b1;
                IC_CLR_IUS:  ius_d = 1'b0;
                IC_SET_IP:   ip_d = 1'b1;
                IC_CLR_IP:   begin ip_d = 1'b0; err_d = 1'b0; end
                IC_SET_IE:   ie_d = 1'b1;
                IC_CLR_IE:   ie_d = 1'b0;
            endcase
        end
        // hardware event wins over a same-cycle clear
        if (tc_evt) begin
            ip_d = 1'b1;
            if (ip) err_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ip  <= 1'b0;
            ie  <= 1'b0;
            ius <= 1'b0;
            err <= 1'b0;
        end else begin
            ip  <= ip_d;
            ie  <= ie_d;
            ius <= ius_d;
            err <= err_d;
        end
    end

    assign irq = ip && ie && !ius;

    // R9: terminal count always leaves pending set
    assert_tc_sets_ip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tc_evt |=> ip);
    // R8: clear-enable command drops the enable flag
    assert_clr_ie_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (icmd_vld && icmd == IC_CLR_IE) |=> !ie);
endmodule

// File: rtl/ctr16_timer.sv
module ctr16_timer
    import ctr16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              cnt_en,
    input  logic              ext_gate,
    input  logic              ext_trig,
    input  logic              ext_cnt,
    output logic              out_pin,
    output logic              irq
);
    mode_t            mode;
    icmd_e            icmd;
    logic [CNT_W-1:0] tconst, count, snap, rd_cnt;
    logic             gate_cmd, sw_trig, icmd_vld, frozen;
    logic             cip, tc_evt, shape_out;
    logic             ip, ie, ius, err;

    ctr16_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .live_cnt(count), .mode(mode), .tconst(tconst),
        .gate_cmd(gate_cmd), .sw_trig(sw_trig), .icmd_vld(icmd_vld), .icmd(icmd),
        .frozen(frozen), .snap(snap)
    );

    ctr16_core u_core (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tconst(tconst), .gate_cmd(gate_cmd),
        .sw_trig(sw_trig), .cnt_en(cnt_en), .ext_gate(ext_gate), .ext_trig(ext_trig),
        .ext_cnt(ext_cnt), .count(count), .cip(cip), .tc_evt(tc_evt),
        .shape_out(shape_out)
    );

    ctr16_irq u_irq (
        .clk(clk), .rst_n(rst_n), .tc_evt(tc_evt), .icmd_vld(icmd_vld), .icmd(icmd),
        .ip(ip), .ie(ie), .ius(ius), .err(err), .irq(irq)
    );

    assign rd_cnt = frozen ? snap : count;

    always_comb begin
        case (addr)
            A_CSR:    rdata = {ius, ie, ip, err, frozen, gate_cmd, 1'b0, cip};
            A_MODE:   rdata = mode;
            A_CNT_HI: rdata = rd_cnt[CNT_W-1:BYTE_W];
            A_CNT_LO: rdata = rd_cnt[BYTE_W-1:0];
            A_TC_HI:  rdata = tconst[CNT_W-1:BYTE_W];
            A_TC_LO:  rdata = tconst[BYTE_W-1:0];
            default:  rdata = '0;
        endcase
    end

    assign out_pin = mode.out_en && shape_out;

    // R10: no request while under service
    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ius |-> !irq);
endmodule

// File: tb/sim_ctr16_timer.sv
module sim_ctr16_timer;
    import ctr16_pkg::*;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       cnt_en = 1'b0, ext_gate = 1'b0, ext_trig = 1'b0, ext_cnt = 1'b0;
    logic [7:0] rdata;
    logic       out_pin, irq;
    int         checks = 0, fails = 0;

    always #5 clk = ~clk;

    ctr16_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en), .ext_gate(ext_gate),
        .ext_trig(ext_trig), .ext_cnt(ext_cnt), .out_pin(out_pin), .irq(irq)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
    localparam int NV = 41;
    // {op, addr, data, expected, requirement number}
    localparam logic [24:0] VEC [NV] = '{
        {OP_WR, A_TC_HI, 8'h00, 8'h00, 4'd1},
        {OP_WR, A_TC_LO, 8'h03, 8'h00, 4'd1},
        {OP_RD, A_TC_HI, 8'h00, 8'h00, 4'd1},   // R1
        {OP_RD, A_TC_LO, 8'h00, 8'h03, 4'd1},
        {OP_WR, A_MODE,  8'h40, 8'h00, 4'd1},
        {OP_RD, A_MODE,  8'h00, 8'h40, 4'd1},
        {OP_WR, A_CSR,   8'h06, 8'h00, 4'd2},
        {OP_RD, A_CSR,   8'h00, 8'h05, 4'd2},   // R2 start
        {OP_RD, A_CNT_LO,8'h00, 8'h03, 4'd2},
        {OP_TK, 3'd0,    8'd2,  8'h00, 4'd3},
        {OP_RD, A_CNT_LO,8'h00, 8'h01, 4'd3},   // R3 decrement
        {OP_TK, 3'd0,    8'd1,  8'h00, 4'd6},
        {OP_RD, A_CSR,   8'h00, 8'h24, 4'd6},   // R6 single stop, pending set
        {OP_RD, A_CNT_LO,8'h00, 8'h00, 4'd6},
        {OP_WR, A_CSR,   8'hC4, 8'h00, 4'd8},
        {OP_RD, A_CSR,   8'h00, 8'h64, 4'd8},   // R8 set enable
        {OP_WR, A_CSR,   8'h44, 8'h00, 4'd8},
        {OP_RD, A_CSR,   8'h00, 8'hE4, 4'd8},   // set under-service
        {OP_WR, A_CSR,   8'h64, 8'h00, 4'd8},
        {OP_RD, A_CSR,   8'h00, 8'h64, 4'd8},   // clear under-service
        {OP_WR, A_CSR,   8'hA4, 8'h00, 4'd8},
        {OP_RD, A_CSR,   8'h00, 8'h44, 4'd8},   // clear pending
        {OP_WR, A_CSR,   8'h84, 8'h00, 4'd8},
        {OP_RD, A_CSR,   8'h00, 8'h64, 4'd8},   // set pending
        {OP_WR, A_CSR,   8'h44, 8'h00, 4'd8},
        {OP_WR, A_CSR,   8'h24, 8'h00, 4'd8},
        {OP_RD, A_CSR,   8'h00, 8'h44, 4'd8},   // clear pending and under-service
        {OP_WR, A_CSR,   8'hE4, 8'h00, 4'd8},
        {OP_RD, A_CSR,   8'h00, 8'h04, 4'd8},   // clear enable
        {OP_WR, A_CSR,   8'h00, 8'h00, 4'd3},
        {OP_WR, A_TC_LO, 8'h05, 8'h00, 4'd3},
        {OP_WR, A_CSR,   8'h02, 8'h00, 4'd2},
        {OP_RD, A_CSR,   8'h00, 8'h01, 4'd2},   // R2 trigger without gate
        {OP_TK, 3'd0,    8'd3,  8'h00, 4'd3},
        {OP_RD, A_CNT_LO,8'h00, 8'h05, 4'd3},   // R3 gate closed holds
        {OP_WR, A_CSR,   8'h04, 8'h00, 4'd3},
        {OP_TK, 3'd0,    8'd2,  8'h00, 4'd3},
        {OP_RD, A_CNT_LO,8'h00, 8'h03, 4'd3},
        {OP_WR, A_MODE,  8'h48, 8'h00, 4'd3},
        {OP_TK, 3'd0,    8'd2,  8'h00, 4'd3},
        {OP_RD, A_CNT_LO,8'h00, 8'h03, 4'd3}    // R3 external gate low holds
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 check(tag, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic pin_chk(input logic act, input logic exp, input string tag);
        #1 check(tag, {7'd0, act}, {7'd0, exp});
    endtask

    task automatic trig_pulse();
        @(negedge clk); ext_trig = 1'b0;
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cnt_en = 1'b0; ext_gate = 1'b0; ext_trig = 1'b0; ext_cnt = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        rd_chk(A_CSR, 8'h00, "R12 status");
        rd_chk(A_MODE, 8'h00, "R12 mode");
        rd_chk(A_CNT_LO, 8'h00, "R12 count");
        pin_chk(out_pin, 1'b0, "R12 out_pin");
        pin_chk(irq, 1'b0, "R12 irq");

        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            case (v[24:23])
                OP_WR: wr(v[22:20], v[19:12]);
                OP_RD: rd_chk(v[22:20], v[11:4], $sformatf("R%0d vec%0d", v[3:0], i));
                default: tick(int'(v[19:12]));
            endcase
        end
        // R3 external gate high lets counting resume
        ext_gate = 1'b1;
        tick(1);
        rd_chk(A_CNT_LO, 8'h02, "R3 ext gate high");

        // continuous square wave with interrupts
        do_reset();
        wr(A_TC_HI, 8'h00); wr(A_TC_LO, 8'h02); wr(A_MODE, 8'hC2);
        wr(A_CSR, 8'hC4); wr(A_CSR, 8'h06);
        pin_chk(out_pin, 1'b0, "R7 square after start");
        tick(2);
        pin_chk(out_pin, 1'b1, "R7 square first flip");
        pin_chk(irq, 1'b1, "R10 irq on pending+enable");
        rd_chk(A_CNT_LO, 8'h02, "R6 continuous reload");
        rd_chk(A_CSR, 8'h65, "R6 continuous keeps running");
        tick(2);
        pin_chk(out_pin, 1'b0, "R7 square second flip");
        rd_chk(A_CSR, 8'h75, "R9 error on repeat terminal count");
        wr(A_CSR, 8'h44);
        pin_chk(irq, 1'b0, "R10 irq masked by under-service");
        wr(A_CSR, 8'h24);
        rd_chk(A_CSR, 8'h45, "R9 clear pending clears error");
        pin_chk(irq, 1'b0, "R10 irq low without pending");
        wr(A_CSR, 8'h84);
        pin_chk(irq, 1'b1, "R10 irq after set pending");
        tick(1);
        @(negedge clk);
        wr_en = 1'b1; addr = A_CSR; wdata = 8'hA4; cnt_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cnt_en = 1'b0;
        rd_chk(A_CSR, 8'h75, "R9 terminal count beats clear");

        // one-shot with external trigger and retrigger
        do_reset();
        rd_chk(A_CSR, 8'h00, "R12 status after second reset");
        wr(A_TC_LO, 8'h04); wr(A_MODE, 8'h51); wr(A_CSR, 8'h04);
        pin_chk(out_pin, 1'b0, "R7 one-shot idle low");
        trig_pulse();
        pin_chk(out_pin, 1'b1, "R7 one-shot high after trigger");
        rd_chk(A_CSR, 8'h05, "R5 ext trigger starts");
        rd_chk(A_CNT_LO, 8'h04, "R5 ext trigger loads");
        tick(2);
        trig_pulse();
        rd_chk(A_CNT_LO, 8'h02, "R5 retrigger ignored when disabled");
        tick(1);
        wr(A_MODE, 8'h55);
        trig_pulse();
        rd_chk(A_CNT_LO, 8'h04, "R5 retrigger reloads");
        tick(4);
        pin_chk(out_pin, 1'b0, "R7 one-shot low at terminal count");
        rd_chk(A_CSR, 8'h24, "R6 single-cycle stop");
        wr(A_MODE, 8'h41);
        trig_pulse();
        rd_chk(A_CSR, 8'h24, "R5 ext trigger ignored when disabled");

        // pulse shape and output enable
        do_reset();
        wr(A_TC_LO, 8'h02); wr(A_MODE, 8'h40); wr(A_CSR, 8'h06);
        tick(1);
        pin_chk(out_pin, 1'b0, "R7 pulse low before end");
        tick(1);
        pin_chk(out_pin, 1'b1, "R7 pulse high at end");
        repeat (2) @(negedge clk);
        pin_chk(out_pin, 1'b1, "R7 pulse holds until next tick");
        wr(A_MODE, 8'h00);
        pin_chk(out_pin, 1'b0, "R7 output disabled");
        wr(A_MODE, 8'h40);
        pin_chk(out_pin, 1'b1, "R7 output re-enabled");
        tick(1);
        pin_chk(out_pin, 1'b0, "R7 pulse ends on tick");

        // external count input
        do_reset();
        wr(A_TC_LO, 8'h03); wr(A_MODE, 8'h60); wr(A_CSR, 8'h06);
        tick(2);
        rd_chk(A_CNT_LO, 8'h03, "R4 cnt_en ignored with external count");
        @(negedge clk); ext_cnt = 1'b1;
        @(negedge clk);
        rd_chk(A_CNT_LO, 8'h02, "R4 ext count edge");
        repeat (3) @(negedge clk);
        rd_chk(A_CNT_LO, 8'h02, "R4 held ext count counts once");
        @(negedge clk); ext_cnt = 1'b0;
        @(negedge clk); ext_cnt = 1'b1;
        @(negedge clk);
        rd_chk(A_CNT_LO, 8'h01, "R4 second ext count edge");

        // read latch
        do_reset();
        wr(A_TC_HI, 8'h12); wr(A_TC_LO, 8'h34); wr(A_MODE, 8'h00); wr(A_CSR, 8'h06);
        tick(1);
        wr(A_CSR, 8'h0C);
        rd_chk(A_CSR, 8'h0D, "R11 latch flag set");
        tick(3);
        rd_chk(A_CNT_HI, 8'h12, "R11 frozen high byte");
        rd_chk(A_CNT_LO, 8'h33, "R11 frozen low byte");
        rd_chk(A_CNT_LO, 8'h30, "R11 live after release");
        rd_chk(A_CSR, 8'h05, "R11 latch flag cleared");

        finish_run();
    end
endmodule